// File: doc/BRIEF.md
# IDE Strobe Timing Generator

This block times single 16-bit accesses to one chip-select region that holds an IDE or SmartMedia style device. A host request, sampled while the block is idle, starts one access. The block drives chip select, byte enables and the two buffer enables, and asserts a read or write strobe. It can hold the strobe while the device pulls its ready line low. It closes the access with a one-clock acknowledge back to the host. No access is ever a burst.

Software sets the timing through configuration inputs. A pre-delay field sets how many whole clocks pass between the start of the access and the strobe. A wait field sets the strobe width to the wait value plus three and a half clocks: the strobe rises on a falling clock edge and is released on a rising edge. A post field lengthens write accesses only. A ready handshake with a fixed timeout keeps a dead device from hanging the bus. A latched flag records that the timeout has fired.

Top module: `ide_strobe_gen`

## Requirements
- R1: `cs_n` goes low in the clock after the edge that accepts a request. It stays low through the acknowledge clock and goes high at the next rising edge. The acknowledge clock is the clock with index pre + wait + 4 + hold + post_extra, counting from 0 at the accepting edge.
- R2: The active strobe first appears at the falling edge inside clock number `cfg_pre` (0 to 3) of the access, so it is delayed by `cfg_pre` whole clocks after the start.
- R3: With no ready hold, the strobe is active for exactly 2·`cfg_wait`+7 half clock periods, and it ends on a rising edge.
- R4: A read (`req_rd`=1) drives `rd_n` low during the strobe and keeps `wr_n` high. A write drives `wr_n` low during the strobe. On a write, `rd_n` goes low as well only when `cfg_rd_on_wr`=1.
- R5: Post code 2 lengthens a write by one clock after the strobe, and code 3 by two clocks. Codes 0 and 1 add nothing. Reads are never lengthened.
- R6: With `cfg_rdy_en`=1, each rising edge at the end of the strobe that sees `dev_rdy` low adds one clock to the strobe. With `cfg_rdy_en`=0, `dev_rdy` has no effect on timing.
- R7: After 256 hold clocks, if ready is still low, the strobe ends anyway and `timeout` goes high. `timeout` stays high until reset.
- R8: With `cfg_ta_en`=1, `ta` is high for exactly the one acknowledge clock of each access. With `cfg_ta_en`=0, `ta` never goes high.
- R9: `buf_en[i]` is high for every clock in which `cs_n` is low, provided `cfg_buf_en[i]`=1. Otherwise it stays low.
- R10: `be_n` carries the inverse of the `req_be` value latched at acceptance for the whole access (bit i enables byte lane i). Outside an access it reads all ones.
- R11: A request raised while an access is in progress is ignored. No second access follows.
- R12: During reset, `cs_n`, `rd_n`, `wr_n` and `be_n` are high, and `ta`, `buf_en` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Chip-select hit, starts an access when idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_be | input | 2 | Byte-lane enables for the access |
| cfg_pre | input | 2 | Strobe pre-delay in clocks |
| cfg_wait | input | 4 | Wait count for the strobe width |
| cfg_post | input | 2 | Write post-hold code |
| cfg_ta_en | input | 1 | Block generates the acknowledge |
| cfg_rdy_en | input | 1 | Enable the device ready handshake |
| cfg_buf_en | input | 2 | Per-buffer enable select |
| cfg_rd_on_wr | input | 1 | Also assert the read strobe on writes |
| dev_rdy | input | 1 | Device ready, low holds the strobe |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| be_n | output | 2 | Byte enables, active low |
| buf_en | output | 2 | Buffer enables, active high |
| ta | output | 1 | Transfer acknowledge pulse |
| timeout | output | 1 | Latched ready-timeout flag |

## Verification
Two functions can fall on the same clock edge. At the edge that would end the strobe, the ready hold may extend the strobe or the post-hold extension may start, and a stale read strobe may coincide with a write. The bench provokes this by releasing `dev_rdy` a chosen number of edges after the access begins, including on the very edge where the strobe would end, and again after the 256-clock limit, on reads and writes with non-zero post codes. A reference timeline computed from the requirements predicts every output at every half period. Explicit measurements of strobe start, strobe width and acknowledge position decide which function won the edge.

// File: rtl/ide_strobe_pkg.sv
package ide_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_STRB = 3'd2,
    ST_POST = 3'd3,
    ST_ACK  = 3'd4
  } seq_state_t;

  // clocks appended after the strobe; writes only
  function automatic logic [1:0] post_extra(input logic [1:0] code, input logic is_wr);
    logic [1:0] ext;
    ext = 2'd0;
    if (is_wr) begin
      if (code == 2'd2) ext = 2'd1;
      else if (code == 2'd3) ext = 2'd2;
    end
    return ext;
  endfunction

endpackage

// File: rtl/ide_hold_timer.sv
module ide_hold_timer #(
  parameter int TMO_CLKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic want,
  output logic hold,
  output logic timeout
);
  localparam int CW = $clog2(TMO_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo_q, tmo_d;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(TMO_CLKS));
  assign hold     = want & ~at_limit;
  assign timeout  = tmo_q;

  always_comb begin
    cnt_d = cnt_q;
    tmo_d = tmo_q;
    if (clr) cnt_d = '0;
    else if (hold) cnt_d = cnt_q + CW'(1);
    if (want && at_limit) tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assert_hold_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TMO_CLKS));

  assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> tmo_q);

endmodule

// File: rtl/ide_seq_fsm.sv
module ide_seq_fsm
  import ide_strobe_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int WAIT_W = 4,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_rd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]        cfg_post,
  input  logic              hold,
  output seq_state_t        state,
  output logic              strb_last,
  output logic              is_rd,
  output logic [BE_W-1:0]   be
);
  localparam int CNT_W = ((WAIT_W + 1) > PRE_W) ? (WAIT_W + 1) : PRE_W;

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rd_q, rd_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic [1:0]        extra;
  logic              pre_last, post_last;

  assign extra     = post_extra(cfg_post, ~rd_q);
  assign strb_last = (st_q == ST_STRB) && (cnt_q == CNT_W'(cfg_wait) + CNT_W'(3));
  assign pre_last  = (cnt_q == CNT_W'(cfg_pre) - CNT_W'(1));
  assign post_last = (cnt_q == CNT_W'(extra) - CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rd_d  = rd_q;
    be_d  = be_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req) begin
          rd_d = req_rd;
          be_d = req_be;
          st_d = (cfg_pre != '0) ? ST_PRE : ST_STRB;
        end
      end
      ST_PRE: begin
        if (pre_last) begin
          cnt_d = '0;
          st_d  = ST_STRB;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_STRB: begin
        if (!strb_last) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else if (!hold) begin
          cnt_d = '0;
          st_d  = (extra != 2'd0) ? ST_POST : ST_ACK;
        end
      end
      ST_POST: begin
        if (post_last) st_d = ST_ACK;
        else cnt_d = cnt_q + CNT_W'(1);
      end
      ST_ACK: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b1;
      be_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      be_q  <= be_d;
    end
  end

  assign state = st_q;
  assign is_rd = rd_q;
  assign be    = be_q;

  // a request seen while busy must not disturb the latched direction
  assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(rd_q) && $stable(be_q));

  assert_reads_not_posted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST) |-> !rd_q);

endmodule

// File: rtl/ide_strobe_out.sv
module ide_strobe_out (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_phase,
  input  logic is_rd,
  input  logic cfg_rd_on_wr,
  output logic rd_n,
  output logic wr_n
);
  logic fall_q;
  logic active;

  // captured on the falling edge: supplies the half-clock of the width
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= strb_phase;
  end

  assign active = strb_phase & fall_q;
  assign rd_n   = ~(active & (is_rd | cfg_rd_on_wr));
  assign wr_n   = ~(active & ~is_rd);

  assert_no_write_strobe_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !is_rd);

  assert_read_on_write_only_if_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !is_rd) |-> cfg_rd_on_wr);

endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen
  import ide_strobe_pkg::*;
#(
  parameter int PRE_W    = 2,
  parameter int WAIT_W   = 4,
  parameter int BE_W     = 2,
  parameter int NUM_BUF  = 2,
  parameter int TMO_CLKS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_rd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]        cfg_post,
  input  logic              cfg_ta_en,
  input  logic              cfg_rdy_en,
  input  logic [NUM_BUF-1:0] cfg_buf_en,
  input  logic              cfg_rd_on_wr,
  input  logic              dev_rdy,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BE_W-1:0]   be_n,
  output logic [NUM_BUF-1:0] buf_en,
  output logic              ta,
  output logic              timeout
);
  logic [1:0]      rst_sync_q;
  logic            rst_i_n;
  seq_state_t      state;
  logic            strb_last, is_rd, hold, want, idle;
  logic [BE_W-1:0] be;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ide_seq_fsm #(.PRE_W(PRE_W), .WAIT_W(WAIT_W), .BE_W(BE_W)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .req(req), .req_rd(req_rd), .req_be(req_be),
    .cfg_pre(cfg_pre), .cfg_wait(cfg_wait), .cfg_post(cfg_post), .hold(hold),
    .state(state), .strb_last(strb_last), .is_rd(is_rd), .be(be)
  );

  assign idle = (state == ST_IDLE);
  assign want = strb_last & cfg_rdy_en & ~dev_rdy;

  ide_hold_timer #(.TMO_CLKS(TMO_CLKS)) u_hold (
    .clk(clk), .rst_n(rst_i_n), .clr(idle), .want(want),
    .hold(hold), .timeout(timeout)
  );

  ide_strobe_out u_strobe (
    .clk(clk), .rst_n(rst_i_n), .strb_phase(state == ST_STRB), .is_rd(is_rd),
    .cfg_rd_on_wr(cfg_rd_on_wr), .rd_n(rd_n), .wr_n(wr_n)
  );

  assign cs_n = idle;
  assign ta   = (state == ST_ACK) & cfg_ta_en;
  assign be_n = idle ? {BE_W{1'b1}} : ~be;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    assign buf_en[i] = ~idle & cfg_buf_en[i];
  end

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    ta |=> !ta);

  assert_cs_released_after_ack_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    ta |=> cs_n);

  assert_strobe_inside_cs_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!rd_n || !wr_n) |-> !cs_n);

endmodule

// File: tb/ide_strobe_gen_tb.sv
module ide_strobe_gen_tb;
  logic       clk, rst_n;
  logic       req, req_rd;
  logic [1:0] req_be, cfg_pre, cfg_post, cfg_buf_en;
  logic [3:0] cfg_wait;
  logic       cfg_ta_en, cfg_rdy_en, cfg_rd_on_wr, dev_rdy;
  logic       cs_n, rd_n, wr_n, ta, timeout;
  logic [1:0] be_n, buf_en;

  int checks = 0;
  int fails  = 0;
  bit exp_tmo = 0;

  ide_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_be(req_be),
    .cfg_pre(cfg_pre), .cfg_wait(cfg_wait), .cfg_post(cfg_post),
    .cfg_ta_en(cfg_ta_en), .cfg_rdy_en(cfg_rdy_en), .cfg_buf_en(cfg_buf_en),
    .cfg_rd_on_wr(cfg_rd_on_wr), .dev_rdy(dev_rdy),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .be_n(be_n), .buf_en(buf_en),
    .ta(ta), .timeout(timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one access; L = number of edges after the start edge that see dev_rdy low
  task automatic run_access(input bit rd, input logic [1:0] be, input int p, input int w,
                            input int post, input bit ta_en, input bit rdy_en,
                            input logic [1:0] bufs, input bit rdw, input int L,
                            input bit pulse);
    int base, h, x, last, first_stb, width, ta_at, cs_len;
    bit hit;
    base = p + w + 3;
    h = 0; hit = 0;
    if (rdy_en && L > base) begin
      h = L - base;
      if (h > 256) begin h = 256; hit = 1; end
    end
    x = 0;
    if (!rd && post == 2) x = 1;
    if (!rd && post == 3) x = 2;
    last = p + w + 4 + h + x;
    first_stb = -1; width = 0; ta_at = -1; cs_len = 0;

    @(posedge clk); #1;
    req = 1; req_rd = rd; req_be = be; cfg_pre = 2'(p); cfg_wait = 4'(w);
    cfg_post = 2'(post); cfg_ta_en = ta_en; cfg_rdy_en = rdy_en;
    cfg_buf_en = bufs; cfg_rd_on_wr = rdw; dev_rdy = 1;
    @(posedge clk);
    for (int n = 0; n <= last + 2; n++) begin
      for (int ph = 0; ph < 2; ph++) begin
        bit act, stb, tmo_e;
        int hs;
        if (ph == 0) begin
          #1;
          req = pulse && (n == 2);
          dev_rdy = !(n + 1 <= L);
        end else begin
          #2;
        end
        hs = 2 * n + ph;
        act = (n <= last);
        stb = (hs >= 2 * p + 1) && (hs <= 2 * (p + w + 4 + h) - 1);
        tmo_e = exp_tmo || (hit && n >= p + w + 4 + h);
        if (!rd_n || !wr_n) begin
          if (first_stb < 0) first_stb = hs;
          width++;
        end
        if (ph == 0 && ta) ta_at = n;
        if (ph == 0 && !cs_n) cs_len++;
        chk(cs_n == !act, (n > last && pulse) ? "R11 cs_n" : "R1 cs_n", cs_n, !act);
        chk(rd_n == !(stb && (rd || rdw)), "R4 rd_n", rd_n, !(stb && (rd || rdw)));
        chk(wr_n == !(stb && !rd), "R4 wr_n", wr_n, !(stb && !rd));
        chk(ta == (ta_en && n == last), "R8 ta", ta, (ta_en && n == last));
        chk(buf_en == (act ? bufs : 2'b00), "R9 buf_en", buf_en, act ? bufs : 2'b00);
        chk(be_n == (act ? ~be : 2'b11), "R10 be_n", be_n, act ? ~be : 2'b11);
        chk(timeout == tmo_e, "R7 timeout", timeout, tmo_e);
      end
      @(posedge clk);
    end
    #1; dev_rdy = 1; req = 0;
    if (hit) exp_tmo = 1;
    chk(first_stb == 2 * p + 1, "R2 strobe start half-slot", first_stb, 2 * p + 1);
    chk(width == 2 * w + 7 + 2 * h, (h > 0) ? "R6 held strobe width" : "R3 strobe width",
        width, 2 * w + 7 + 2 * h);
    chk(cs_len == last + 1, (x > 0 || post > 1) ? "R5 access length" : "R1 access length",
        cs_len, last + 1);
    if (ta_en) chk(ta_at == last, "R8 ack position", ta_at, last);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req = 0; req_rd = 1; req_be = 2'b11; cfg_pre = 0; cfg_wait = 1;
    cfg_post = 0; cfg_ta_en = 1; cfg_rdy_en = 0; cfg_buf_en = 0; cfg_rd_on_wr = 0;
    dev_rdy = 1;
    #7;
    // R12 reset values
    chk(cs_n == 1 && rd_n == 1 && wr_n == 1, "R12 strobes/cs in reset", {cs_n, rd_n, wr_n}, 7);
    chk(be_n == 2'b11, "R12 be_n in reset", be_n, 3);
    chk(ta == 0 && buf_en == 0 && timeout == 0, "R12 ta/buf/timeout in reset",
        {ta, buf_en, timeout}, 0);
    #6 rst_n = 1;
    repeat (4) @(posedge clk);

    run_access(1, 2'b11, 0, 1, 0, 1, 0, 2'b01, 0, 0, 0);   // R3 basic read
    run_access(1, 2'b01, 2, 2, 3, 1, 0, 2'b11, 0, 0, 0);   // R2, R5 read not extended
    run_access(0, 2'b10, 0, 1, 2, 1, 0, 2'b10, 0, 0, 0);   // R5 write +1
    run_access(0, 2'b11, 1, 3, 3, 0, 0, 2'b00, 1, 0, 0);   // R5 +2, R4 rd on wr, R8 no ack
    run_access(0, 2'b01, 3, 0, 1, 1, 0, 2'b11, 0, 0, 1);   // R5 code1, R11 mid pulse
    run_access(1, 2'b11, 1, 2, 0, 1, 1, 2'b01, 0, 1 + 2 + 3 + 5, 0); // R6 hold 5
    run_access(0, 2'b11, 0, 1, 2, 1, 1, 2'b01, 0, 0 + 1 + 3 + 1, 0); // R6 hold on edge, then post
    run_access(1, 2'b10, 0, 2, 0, 1, 0, 2'b10, 0, 20, 0);  // R6 ready ignored
    run_access(1, 2'b11, 0, 1, 0, 1, 1, 2'b11, 0, 300, 0); // R7 timeout
    run_access(0, 2'b01, 1, 1, 3, 1, 0, 2'b01, 0, 0, 0);   // R7 flag stays set

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule